// File: doc/BRIEF.md
# Power-Down Clock Shutdown Sequencer

This block sits beside the output gating of a multi-output clock generator. It watches an active-low power-down request. When the request holds, it brings every generated clock output to a quiet low level, drops the enables of the PLLs and the crystal oscillator, and tri-states the serial control pins. When the request is released, it restarts the sources first. It waits a programmable settle interval, then lets each output resume with whole pulses only. The control runs from the fastest (CPU-domain) clock.

Each output has an enable flop clocked on the falling edge of that output's own source clock. The gate can therefore open or close only while that clock is low. A parameter mask selects outputs that must go quiet at once instead of waiting for their own falling edge. These are the slow reference output and the USB-rate output. For those outputs the enable is cleared asynchronously. Register contents of the serial interface live outside this block and are untouched. The block only reports that the interface must stay off.

Top module: `pwrdn_seq`

## Requirements
- R1: `pdReqN` high means run. In reset, `pllEn` = `oscEn` = 1, `serialOff` = 0 and all `gateEn` bits are 0. After reset, every `gateEn` bit becomes 1 on its own source's first falling edge.
- R2: The request passes through a two-flop synchronizer and must then be seen low on two consecutive `cpuClk` rising edges. A request driven low before edge 1 and held takes effect at edge 4, which is when `pllEn` falls. A low lasting a single `cpuClk` cycle is ignored.
- R3: An output whose `IMM_MASK` bit is 0 has its enable cleared only at its own source's falling edge. Every high pulse on it is a full half period, and it is held low for the whole power-down.
- R4: An output whose `IMM_MASK` bit is 1 (default bits 4 and 5) has its enable cleared in the same `cpuClk` cycle that power-down takes effect, whatever the phase of its source.
- R5: While powered down, `pllEn` and `oscEn` are 0 and `serialOff` is 1. `serialOff` is 1 whenever the outputs are not released.
- R6: After the request is released, `pllEn` and `oscEn` rise at the third `cpuClk` edge. The outputs stay stopped for `settleCount`+1 cycles; `serialOff` then falls, and no enable rises before that.
- R7: On restart, each enable rises only while its source is low, so every first pulse is whole. All enables are back within one source period.
- R8: A request seen low (after synchronization) during the settle interval returns the block to power-down at once, at the third `cpuClk` edge, without the two-edge qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | Fastest clock; runs the control |
| rstN | input | 1 | Asynchronous active-low reset |
| pdReqN | input | 1 | Active-low power-down request, asynchronous |
| settleCount | input | SETTLE_W | Settle length in cycles, minus one |
| srcClk | input | NUM_OUT | Source clocks of the gated outputs |
| gateEn | output | NUM_OUT | Per-output gate enables |
| gatedClk | output | NUM_OUT | Gated output clocks |
| pllEn | output | 1 | PLL enable |
| oscEn | output | 1 | Crystal oscillator enable |
| serialOff | output | 1 | 1 = serial control pins tri-stated |

## Verification
Two events can meet in one instant: the asynchronous stop of an immediate output and that output's own falling-edge enable flop. A stop can also land while a slow source is high, and a restart can come so soon after a stop that slow outputs have not yet closed. The two-cycle request vector provokes this: it enters and leaves power-down within two cycles. The six source clocks have unrelated half periods, so their phases at entry differ from vector to vector. A monitor times every gated pulse. Each rise must fall on a source rising edge, and each pulse must be a full half period, or no longer than one for the immediate outputs.

// File: rtl/pwrdn_pkg.sv
`timescale 1ns/1ps
package pwrdn_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DOWN   = 2'd1,
    ST_SETTLE = 2'd2
  } pdState_t;

  // strobe bundle from control to the gating datapath
  typedef struct packed {
    logic stopReq;
  } pdStrobe_t;
endpackage

// File: rtl/pwrdn_ctrl.sv
`timescale 1ns/1ps
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int SETTLE_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                cpuClk,
  input  logic                rstN,
  input  logic                pdReqN,
  input  logic [SETTLE_W-1:0] settleCount,
  output pdStrobe_t           strobe,
  output logic                pllEn,
  output logic                oscEn,
  output logic                serialOff
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]         syncQ;
  logic                  reqLow;
  pdState_t              state, nextState;
  logic [SETTLE_W-1:0]   cnt, nextCnt;
  logic                  lowSeen, nextLowSeen;
  logic                  stopQ;

  // request synchronizer, idle value is "run"
  always_ff @(posedge cpuClk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[LAST-1:0], pdReqN};
  end
  assign reqLow = ~syncQ[LAST];

  always_comb begin
    nextState   = state;
    nextCnt     = cnt;
    nextLowSeen = 1'b0;
    unique case (state)
      ST_RUN: begin
        nextLowSeen = reqLow;
        if (reqLow && lowSeen) nextState = ST_DOWN;
      end
      ST_DOWN: begin
        if (!reqLow) begin
          nextState = ST_SETTLE;
          nextCnt   = settleCount;
        end
      end
      ST_SETTLE: begin
        if (reqLow)          nextState = ST_DOWN;
        else if (cnt == '0)  nextState = ST_RUN;
        else                 nextCnt   = cnt - 1'b1;
      end
      default: nextState = ST_DOWN;
    endcase
  end

  // outputs registered from next state so they never glitch
  always_ff @(posedge cpuClk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_RUN;
      cnt       <= '0;
      lowSeen   <= 1'b0;
      pllEn     <= 1'b1;
      oscEn     <= 1'b1;
      serialOff <= 1'b0;
      stopQ     <= 1'b0;
    end else begin
      state     <= nextState;
      cnt       <= nextCnt;
      lowSeen   <= nextLowSeen;
      pllEn     <= (nextState != ST_DOWN);
      oscEn     <= (nextState != ST_DOWN);
      serialOff <= (nextState != ST_RUN);
      stopQ     <= (nextState != ST_RUN);
    end
  end

  assign strobe.stopReq = stopQ;
endmodule

// File: rtl/pwrdn_gate.sv
`timescale 1ns/1ps
module pwrdn_gate
  import pwrdn_pkg::*;
#(
  parameter int                   NUM_OUT  = 6,
  parameter logic [NUM_OUT-1:0]   IMM_MASK = 6'b110000
) (
  input  logic               rstN,
  input  logic [NUM_OUT-1:0] srcClk,
  input  pdStrobe_t          strobe,
  output logic [NUM_OUT-1:0] gateEn,
  output logic [NUM_OUT-1:0] gatedClk
);
  logic stopReq;
  assign stopReq = strobe.stopReq;

  for (genvar i = 0; i < NUM_OUT; i++) begin : gOut
    logic enQ;
    if (IMM_MASK[i]) begin : gImm
      // cleared at once by the stop strobe, raised only on the low phase
      always_ff @(negedge srcClk[i] or negedge rstN or posedge stopReq) begin
        if (!rstN)        enQ <= 1'b0;
        else if (stopReq) enQ <= 1'b0;
        else              enQ <= 1'b1;
      end
    end else begin : gEdge
      always_ff @(negedge srcClk[i] or negedge rstN) begin
        if (!rstN) enQ <= 1'b0;
        else       enQ <= ~stopReq;
      end
    end
    assign gateEn[i]   = enQ;
    assign gatedClk[i] = srcClk[i] & enQ;
  end
endmodule

// File: rtl/pwrdn_seq.sv
`timescale 1ns/1ps
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int                 NUM_OUT  = 6,
  parameter logic [NUM_OUT-1:0] IMM_MASK = 6'b110000,
  parameter int                 SETTLE_W = 8
) (
  input  logic                cpuClk,
  input  logic                rstN,
  input  logic                pdReqN,
  input  logic [SETTLE_W-1:0] settleCount,
  input  logic [NUM_OUT-1:0]  srcClk,
  output logic [NUM_OUT-1:0]  gateEn,
  output logic [NUM_OUT-1:0]  gatedClk,
  output logic                pllEn,
  output logic                oscEn,
  output logic                serialOff
);
  pdStrobe_t strobe;

  pwrdn_ctrl #(.SETTLE_W(SETTLE_W), .SYNC_STAGES(2)) ctrl (
    .cpuClk      (cpuClk),
    .rstN        (rstN),
    .pdReqN      (pdReqN),
    .settleCount (settleCount),
    .strobe      (strobe),
    .pllEn       (pllEn),
    .oscEn       (oscEn),
    .serialOff   (serialOff)
  );

  pwrdn_gate #(.NUM_OUT(NUM_OUT), .IMM_MASK(IMM_MASK)) gate (
    .rstN     (rstN),
    .srcClk   (srcClk),
    .strobe   (strobe),
    .gateEn   (gateEn),
    .gatedClk (gatedClk)
  );
endmodule

// File: rtl/pwrdn_seq_chk.sv
`timescale 1ns/1ps
module pwrdn_seq_chk #(
  parameter int                 NUM_OUT  = 6,
  parameter logic [NUM_OUT-1:0] IMM_MASK = 6'b110000
) (
  input logic               cpuClk,
  input logic               rstN,
  input logic               pdReqN,
  input logic [NUM_OUT-1:0] srcClk,
  input logic [NUM_OUT-1:0] gateEn,
  input logic               pllEn,
  input logic               oscEn,
  input logic               serialOff
);
  // R5
  pll_osc_match_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    pllEn == oscEn);

  // R5
  down_serial_off_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    !pllEn |-> serialOff);

  // R5
  entry_together_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    $rose(serialOff) |-> !pllEn);

  // R2
  entry_qualified_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    $fell(pllEn) |-> !$past(pdReqN, 3));

  // R6
  restart_after_settle_chk: assert property (@(posedge cpuClk) disable iff (!rstN)
    $fell(serialOff) |-> (pllEn && $past(pllEn)));

  for (genvar i = 0; i < NUM_OUT; i++) begin : gChk
    always @(posedge gateEn[i]) begin
      if (rstN) begin
        // R7
        gate_rise_low_chk: assert (!srcClk[i]);
      end
    end
    if (!IMM_MASK[i]) begin : gEdge
      always @(negedge gateEn[i]) begin
        if (rstN) begin
          // R3
          gate_fall_low_chk: assert (!srcClk[i]);
        end
      end
    end
  end
endmodule

bind pwrdn_seq pwrdn_seq_chk #(.NUM_OUT(NUM_OUT), .IMM_MASK(IMM_MASK)) seqChk (.*);

// File: tb/pwrdn_seq_test.sv
`timescale 1ns/1ps
module pwrdn_seq_test;
  localparam int         N   = 6;
  localparam logic [5:0] IMM = 6'b110000;
  localparam int NVEC = 6;
  // {request low cycles, settle count, expect power-down}
  localparam int VEC [NVEC][3] = '{
    '{1, 4, 0}, '{2, 3, 1}, '{6, 0, 1}, '{24, 10, 1}, '{40, 2, 1}, '{30, 37, 1}
  };

  function automatic real halfOf(input int i);
    case (i)
      0: return 5.0;
      1: return 7.0;
      2: return 15.0;
      3: return 11.0;
      4: return 35.0;
      default: return 10.0;
    endcase
  endfunction

  logic       cpuClk = 1'b0;
  logic       rstN;
  logic       pdReqN;
  logic [7:0] settleCount;
  wire  [5:0] srcClk;
  logic [5:0] gateEn, gatedClk;
  logic       pllEn, oscEn, serialOff;
  int checks = 0, errors = 0, badPulse = 0, pulses = 0;

  always #2.5 cpuClk = ~cpuClk;

  pwrdn_seq #(.NUM_OUT(N), .IMM_MASK(IMM), .SETTLE_W(8)) uut (
    .cpuClk(cpuClk), .rstN(rstN), .pdReqN(pdReqN), .settleCount(settleCount),
    .srcClk(srcClk), .gateEn(gateEn), .gatedClk(gatedClk),
    .pllEn(pllEn), .oscEn(oscEn), .serialOff(serialOff)
  );

  // source clocks and pulse monitors (R3, R4, R7)
  for (genvar g = 0; g < N; g++) begin : gSrc
    logic c = 1'b0;
    realtime riseT = 0.0;
    assign srcClk[g] = c;
    initial begin
      #0.3;
      forever #(halfOf(g)) c = ~c;
    end
    always @(posedge gatedClk[g]) begin
      real ph;
      ph = ($realtime - 0.3 - halfOf(g)) / (2.0 * halfOf(g));
      ph = ph - $floor(ph);
      riseT = $realtime;
      if (ph > 0.001 && ph < 0.999) badPulse++;
    end
    always @(negedge gatedClk[g]) begin
      real w;
      w = $realtime - riseT;
      pulses++;
      if (IMM[g]) begin
        if (w > halfOf(g) + 0.01) badPulse++;
      end else if (w < halfOf(g) - 0.01 || w > halfOf(g) + 0.01) begin
        badPulse++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic sample();
    @(posedge cpuClk);
    #1;
  endtask

  task automatic runVec(input int lowLen, input int settle, input int expDown);
    int firstDown = -1, upC = -1, fallC = -1, earlyRise = 0;
    logic [5:0] prevG;
    settleCount = settle[7:0];
    @(negedge cpuClk);
    pdReqN = 1'b0;
    prevG = gateEn;
    for (int c = 1; c <= lowLen + settle + 25; c++) begin
      sample();
      if (!pllEn && firstDown < 0) begin
        firstDown = c;
        check((gateEn & IMM) == 0, "R4", "immediate enables at entry", gateEn & IMM, 0);
      end
      if (firstDown >= 0 && pllEn && upC < 0) upC = c;
      if (upC >= 0 && !serialOff && fallC < 0) fallC = c;
      if (serialOff && ((gateEn & ~prevG) != 0)) earlyRise++;
      prevG = gateEn;
      if (expDown != 0 && lowLen >= 20 && c == lowLen) begin
        check(gateEn == 0, "R3", "all enables off while down", gateEn, 0);
        check(gatedClk == 0, "R3", "outputs quiet while down", gatedClk, 0);
        check(serialOff && !pllEn && !oscEn, "R5", "sources off, serial off",
              {serialOff, pllEn, oscEn}, 3'b100);
      end
      if (fallC > 0 && c == fallC + 16)
        check(gateEn == 6'h3f, "R7", "all enables back", gateEn, 6'h3f);
      if (c == lowLen) begin
        @(negedge cpuClk);
        pdReqN = 1'b1;
      end
    end
    if (expDown != 0) begin
      check(firstDown == 4, "R2", "entry cycle", firstDown, 4);
      check(upC == lowLen + 3, "R6", "source restart cycle", upC, lowLen + 3);
      check(fallC - upC == settle + 1, "R6", "settle length", fallC - upC, settle + 1);
      check(earlyRise == 0, "R6", "enables raised before release", earlyRise, 0);
    end else begin
      check(firstDown == -1, "R2", "one-cycle request ignored", firstDown, -1);
    end
    repeat (20) @(posedge cpuClk);
  endtask

  initial begin
    #200000;
    check(1'b0, "WD", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0;
    pdReqN = 1'b1;
    settleCount = 8'd0;
    repeat (3) sample();
    // R1 reset state
    check(pllEn && oscEn && !serialOff, "R1", "reset controls",
          {pllEn, oscEn, serialOff}, 3'b110);
    check(gateEn == 0, "R1", "reset enables", gateEn, 0);
    @(negedge cpuClk);
    rstN = 1'b1;
    repeat (20) sample();
    check(gateEn == 6'h3f, "R1", "enables after reset", gateEn, 6'h3f);

    // table-driven entry/exit sequences (R2..R7)
    for (int v = 0; v < NVEC; v++)
      runVec(VEC[v][0], VEC[v][1], VEC[v][2]);

    // R8: request again during the settle interval
    settleCount = 8'd40;
    @(negedge cpuClk);
    pdReqN = 1'b0;
    repeat (12) sample();
    @(negedge cpuClk);
    pdReqN = 1'b1;
    for (int k = 0; k < 10; k++) begin
      sample();
      if (pllEn) break;
    end
    check(pllEn && serialOff, "R8", "in settle before re-request",
          {pllEn, serialOff}, 2'b11);
    @(negedge cpuClk);
    pdReqN = 1'b0;
    sample();
    sample();
    check(pllEn == 1'b1, "R8", "still settling at edge 2", pllEn, 1);
    sample();
    check(pllEn == 1'b0, "R8", "back down at edge 3", pllEn, 0);
    repeat (10) sample();
    @(negedge cpuClk);
    pdReqN = 1'b1;
    repeat (80) sample();
    check(gateEn == 6'h3f && !serialOff, "R7", "running after re-entry",
          {serialOff, gateEn}, 7'h3f);

    // R3 / R4 / R7 pulse integrity over the whole run
    check(badPulse == 0, "R3", "partial or misaligned pulses", badPulse, 0);
    check(pulses > 100, "R7", "outputs toggled", pulses, 101);
    summary();
    $finish;
  end
endmodule